// File: doc/BRIEF.md
# FIFO Interrupt Source Controller

This block gathers the interrupt causes of a serial port's extension FIFOs and drives a single interrupt line toward the host. Five sources are handled here: receive FIFO at or above half, character timeout, transmit FIFO becoming empty, transmit FIFO draining below half, and interval timer expiry. Each source latches or follows its condition, and each is cleared only by its own host actions. Those actions are status reads, FIFO reads or writes, and disabling the timer. An enable register masks the sources. The interrupt request of the UART core is ORed in without masking.

The host reaches four byte-wide registers over a small address/data bus with read and write strobes. The registers are a mode register, an enable register, a read-only status register and a timer control register. The FIFO level flags, the FIFO access strobes, the timeout detector and the timer counter sit outside the block. They arrive as plain inputs. The output is either a registered level or a one-clock pulse for each new rise of the combined request.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the irq output is 0, the mode, enable and timer control registers read 0, and the output style is pulse.
- R2: The registers sit at these offsets: mode at 0, enable at 1, status at 2 (read only, writes ignored), timer control at 3. Mode, enable and timer control read back the full byte last written. Offsets 4 to 7 read 0. The read data is 0 when the read strobe is low.
- R3: The receive source (enable bit 0) follows rx_half_i. It clears only when the FIFO drops below half, and receive FIFO reads have no effect on it while the FIFO stays at half or more.
- R4: A char_tmo_i pulse sets the character timeout source (enable bit 3, status bit 6). It is cleared by a receive FIFO read or by a status read.
- R5: A 0-to-1 change of tx_empty_i sets the transmit empty source (enable bit 2). A transmit FIFO write or a status read clears it. A FIFO that stays empty does not set it again.
- R6: A 1-to-0 change of tx_half_i sets the transmit half source (enable bit 1). It is cleared when tx_half_i is 1 (writes filled the FIFO to half) or by a status read.
- R7: A timer_tick_i pulse sets the timer source (enable bit 4, status bit 7), but only while timer control bit 0 is 1. Status reads do not clear it. Only a write of timer control with bit 0 equal to 0 clears it.
- R8: A source whose enable bit is 0 does not drive irq_o.
- R9: With mode bit 4 = 1 (level), irq_o equals the OR of the enabled sources and uart_irq_i, delayed by one clock.
- R10: With mode bit 4 = 0 (pulse), irq_o is high for exactly one clock after each 0-to-1 change of that OR. A further source rising while the OR is already 1 gives no pulse.
- R11: uart_irq_i reaches irq_o whatever the enable register holds.
- R12: When a character timeout pulse and a status read fall in the same clock, the timeout source stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one clock per write |
| rd_i | input | 1 | Read strobe, one clock per read |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| rx_half_i | input | 1 | Receive FIFO at or above half |
| rx_rd_i | input | 1 | Host popped the receive FIFO this clock |
| char_tmo_i | input | 1 | Character timeout detected (pulse) |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_wr_i | input | 1 | Host pushed the transmit FIFO this clock |
| tx_half_i | input | 1 | Transmit FIFO at or above half |
| timer_tick_i | input | 1 | Interval timer expired (pulse) |
| uart_irq_i | input | 1 | UART core interrupt, passed through |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The hardest situations to reach are collisions between a set event and a clear event in the same clock. One case is a timeout pulse arriving together with a status read. Another is a transmit write landing while the FIFO stays empty, which must not re-arm the source. The bench drives both strobes in the same half-cycle to force these collisions. It then watches irq_o with only that one source enabled. The transmit sources have no status bit, so their latched state is observed only through irq_o in level mode.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int N_SRC = 5;
  // source / enable bit positions
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;
  // register offsets
  localparam int REG_MODE = 0;
  localparam int REG_IEN  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_TCTL = 3;
  // field positions
  localparam int MODE_LVL_BIT = 4;
  localparam int STAT_TMR_BIT = 7;
  localparam int STAT_CTO_BIT = 6;
  localparam int TCTL_EN_BIT  = 0;
endpackage

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pend_tmr_i,
  input  logic              pend_cto_i,
  output logic              level_mode_o,
  output logic [N_SRC-1:0]  ien_o,
  output logic              tmr_en_o,
  output logic              stat_rd_o,
  output logic              tmr_off_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_TCTL = ADDR_W'(REG_TCTL);

  logic [DATA_W-1:0] mode_q, mode_d, ien_q, ien_d, tctl_q, tctl_d;
  logic wr_mode, wr_ien, wr_tctl;

  assign wr_mode = wr_i && (addr_i == A_MODE);
  assign wr_ien  = wr_i && (addr_i == A_IEN);
  assign wr_tctl = wr_i && (addr_i == A_TCTL);

  always_comb begin
    mode_d = wr_mode ? wdata_i : mode_q;
    ien_d  = wr_ien  ? wdata_i : ien_q;
    tctl_d = wr_tctl ? wdata_i : tctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
      tctl_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_ien)  ien_q  <= ien_d;
      if (wr_tctl) tctl_q <= tctl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_MODE: rdata_o = mode_q;
        A_IEN:  rdata_o = ien_q;
        A_STAT: begin
          rdata_o[STAT_TMR_BIT] = pend_tmr_i;
          rdata_o[STAT_CTO_BIT] = pend_cto_i;
        end
        A_TCTL: rdata_o = tctl_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign level_mode_o = mode_q[MODE_LVL_BIT];
  assign ien_o        = ien_q[N_SRC-1:0];
  assign tmr_en_o     = tctl_q[TCTL_EN_BIT];
  assign stat_rd_o    = rd_i && (addr_i == A_STAT);
  assign tmr_off_o    = wr_tctl && !wdata_i[TCTL_EN_BIT];

  // R2: the status offset is read only
  assert_stat_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_STAT) |=> ($stable(mode_q) && $stable(ien_q) && $stable(tctl_q)));
endmodule

// File: rtl/fifo_irq_sources.sv
module fifo_irq_sources
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_half_i,
  input  logic             rx_rd_i,
  input  logic             char_tmo_i,
  input  logic             tx_empty_i,
  input  logic             tx_wr_i,
  input  logic             tx_half_i,
  input  logic             timer_tick_i,
  input  logic             stat_rd_i,
  input  logic             tmr_en_i,
  input  logic             tmr_off_i,
  output logic [N_SRC-1:0] pend_o
);
  logic cto_q, cto_d, txe_q, txe_d, txh_q, txh_d, tmr_q, tmr_d;
  logic txe_seen_q, txh_seen_q;
  logic txe_rise, txh_fall;

  assign txe_rise = tx_empty_i && !txe_seen_q;
  assign txh_fall = !tx_half_i && txh_seen_q;

  always_comb begin
    // a new event wins over a clear in the same clock
    if (char_tmo_i)                cto_d = 1'b1;
    else if (rx_rd_i || stat_rd_i) cto_d = 1'b0;
    else                           cto_d = cto_q;

    if (txe_rise)                  txe_d = 1'b1;
    else if (tx_wr_i || stat_rd_i) txe_d = 1'b0;
    else                           txe_d = txe_q;

    if (txh_fall)                    txh_d = 1'b1;
    else if (tx_half_i || stat_rd_i) txh_d = 1'b0;
    else                             txh_d = txh_q;

    // disabling the timer is the only clear
    if (tmr_off_i)                     tmr_d = 1'b0;
    else if (timer_tick_i && tmr_en_i) tmr_d = 1'b1;
    else                               tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cto_q      <= 1'b0;
      txe_q      <= 1'b0;
      txh_q      <= 1'b0;
      tmr_q      <= 1'b0;
      txe_seen_q <= 1'b1;
      txh_seen_q <= 1'b0;
    end else begin
      cto_q      <= cto_d;
      txe_q      <= txe_d;
      txh_q      <= txh_d;
      tmr_q      <= tmr_d;
      txe_seen_q <= tx_empty_i;
      txh_seen_q <= tx_half_i;
    end
  end

  always_comb begin
    pend_o          = '0;
    pend_o[SRC_RXH] = rx_half_i;
    pend_o[SRC_TXH] = txh_q;
    pend_o[SRC_TXE] = txe_q;
    pend_o[SRC_CTO] = cto_q;
    pend_o[SRC_TMR] = tmr_q;
  end

  assert_cto_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_rd_i || stat_rd_i) && !char_tmo_i) |=> !cto_q);
  assert_cto_setwins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    char_tmo_i |=> cto_q);
  assert_txe_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_wr_i || stat_rd_i) && !tx_empty_i) |=> !txe_q);
  assert_txh_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half_i |=> !txh_q);
  assert_timer_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q && !tmr_off_i) |=> tmr_q);
endmodule

// File: rtl/fifo_irq_out.sv
module fifo_irq_out
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] ien_i,
  input  logic             uart_irq_i,
  input  logic             level_mode_i,
  output logic             irq_o
);
  logic any_req, any_q, irq_q, irq_d;

  assign any_req = (|(pend_i & ien_i)) || uart_irq_i;

  always_comb begin
    if (level_mode_i) irq_d = any_req;
    else              irq_d = any_req && !any_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      any_q <= any_req;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_edge_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !level_mode_i) |=> (!irq_o || level_mode_i));
  assert_level_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode_i && ien_i[SRC_RXH] && pend_i[SRC_RXH]) |=> irq_o);
  assert_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode_i && uart_irq_i) |=> irq_o);
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode_i && !uart_irq_i && ((pend_i & ien_i) == '0)) |=> !irq_o);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_half_i,
  input  logic              rx_rd_i,
  input  logic              char_tmo_i,
  input  logic              tx_empty_i,
  input  logic              tx_wr_i,
  input  logic              tx_half_i,
  input  logic              timer_tick_i,
  input  logic              uart_irq_i,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [N_SRC-1:0] pend, ien;
  logic             level_mode, tmr_en, stat_rd, tmr_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fifo_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .pend_tmr_i(pend[SRC_TMR]), .pend_cto_i(pend[SRC_CTO]),
    .level_mode_o(level_mode), .ien_o(ien), .tmr_en_o(tmr_en),
    .stat_rd_o(stat_rd), .tmr_off_o(tmr_off)
  );

  fifo_irq_sources u_src (
    .clk(clk), .rst_n(rst_ni), .rx_half_i(rx_half_i), .rx_rd_i(rx_rd_i),
    .char_tmo_i(char_tmo_i), .tx_empty_i(tx_empty_i), .tx_wr_i(tx_wr_i),
    .tx_half_i(tx_half_i), .timer_tick_i(timer_tick_i), .stat_rd_i(stat_rd),
    .tmr_en_i(tmr_en), .tmr_off_i(tmr_off), .pend_o(pend)
  );

  fifo_irq_out u_out (
    .clk(clk), .rst_n(rst_ni), .pend_i(pend), .ien_i(ien),
    .uart_irq_i(uart_irq_i), .level_mode_i(level_mode), .irq_o(irq_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_ni |=> (!irq_o || !rst_ni));
endmodule

// File: tb/fifo_irq_ctrl_test.sv
module fifo_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic wr, rd, rx_half, rx_rd, char_tmo, tx_empty, tx_wr, tx_half, tick, uart_irq, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .rx_half_i(rx_half), .rx_rd_i(rx_rd), .char_tmo_i(char_tmo),
    .tx_empty_i(tx_empty), .tx_wr_i(tx_wr), .tx_half_i(tx_half),
    .timer_tick_i(tick), .uart_irq_i(uart_irq), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    nxt(); addr = a; wdata = d; wr = 1'b1;
    nxt(); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
    nxt(); addr = a; rd = 1'b1; #1 d = rdata;
    nxt(); rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    bus_rd(3'd0, v); check("R1 mode reset", v, 8'h00);
    bus_rd(3'd1, v); check("R1 enable reset", v, 8'h00);
    bus_rd(3'd3, v); check("R1 timer ctrl reset", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_wr(3'd0, 8'hA5); bus_rd(3'd0, v); check("R2 mode readback", v, 8'hA5);
    bus_wr(3'd1, 8'hE0); bus_rd(3'd1, v); check("R2 enable readback", v, 8'hE0);
    bus_wr(3'd3, 8'h06); bus_rd(3'd3, v); check("R2 tctl readback", v, 8'h06);
    bus_wr(3'd2, 8'hFF); bus_rd(3'd2, v); check("R2 status write ignored", v, 8'h00);
    bus_wr(3'd5, 8'hFF); bus_rd(3'd5, v); check("R2 unused offset", v, 8'h00);
    nxt(); check("R2 rdata idle", rdata, 8'h00);
    bus_wr(3'd3, 8'h00); bus_wr(3'd1, 8'h00);
    bus_wr(3'd0, 8'h10);
  endtask

  task automatic t_rxhalf();
    bus_wr(3'd1, 8'h01);
    rx_half = 1'b1; nxt(); check("R9 level rx irq", {7'b0, irq}, 8'h01);
    rx_rd = 1'b1; nxt(); rx_rd = 1'b0; nxt();
    check("R3 rx read above half keeps irq", {7'b0, irq}, 8'h01);
    rx_half = 1'b0; nxt(); check("R3 below half clears", {7'b0, irq}, 8'h00);
    bus_wr(3'd1, 8'h00);
    rx_half = 1'b1; nxt(); nxt(); check("R8 masked rx", {7'b0, irq}, 8'h00);
    rx_half = 1'b0; nxt();
  endtask

  task automatic t_cto();
    logic [7:0] v;
    bus_wr(3'd1, 8'h08);
    char_tmo = 1'b1; nxt(); char_tmo = 1'b0; nxt();
    check("R4 timeout irq", {7'b0, irq}, 8'h01);
    bus_rd(3'd2, v); check("R4 status bit6", v, 8'h40);
    nxt(); check("R4 status read clears", {7'b0, irq}, 8'h00);
    char_tmo = 1'b1; nxt(); char_tmo = 1'b0; nxt();
    check("R4 timeout again", {7'b0, irq}, 8'h01);
    rx_rd = 1'b1; nxt(); rx_rd = 1'b0; nxt();
    check("R4 rx read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_setwins();
    logic [7:0] v;
    bus_wr(3'd1, 8'h08);
    nxt(); addr = 3'd2; rd = 1'b1; char_tmo = 1'b1;
    nxt(); rd = 1'b0; char_tmo = 1'b0;
    nxt(); check("R12 set beats status read", {7'b0, irq}, 8'h01);
    bus_rd(3'd2, v); nxt();
    check("R12 later read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_txe();
    logic [7:0] v;
    bus_wr(3'd1, 8'h04);
    tx_empty = 1'b1; nxt(); nxt(); check("R5 empty rise irq", {7'b0, irq}, 8'h01);
    tx_wr = 1'b1; nxt(); tx_wr = 1'b0; nxt();
    check("R5 tx write clears", {7'b0, irq}, 8'h00);
    nxt(); check("R5 still empty no re-arm", {7'b0, irq}, 8'h00);
    tx_empty = 1'b0; nxt(); tx_empty = 1'b1; nxt(); nxt();
    check("R5 second rise", {7'b0, irq}, 8'h01);
    bus_rd(3'd2, v); nxt(); check("R5 status read clears", {7'b0, irq}, 8'h00);
    tx_empty = 1'b0; nxt();
  endtask

  task automatic t_txh();
    logic [7:0] v;
    bus_wr(3'd1, 8'h02);
    tx_half = 1'b1; nxt(); nxt();
    check("R6 at half no irq", {7'b0, irq}, 8'h00);
    tx_half = 1'b0; nxt(); nxt(); check("R6 drain below half", {7'b0, irq}, 8'h01);
    tx_half = 1'b1; nxt(); nxt(); check("R6 refill clears", {7'b0, irq}, 8'h00);
    tx_half = 1'b0; nxt(); nxt(); check("R6 drain again", {7'b0, irq}, 8'h01);
    bus_rd(3'd2, v); nxt(); check("R6 status read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    bus_wr(3'd1, 8'h10);
    tick = 1'b1; nxt(); tick = 1'b0; nxt();
    check("R7 tick ignored when disabled", {7'b0, irq}, 8'h00);
    bus_wr(3'd3, 8'h01);
    tick = 1'b1; nxt(); tick = 1'b0; nxt();
    check("R7 timer irq", {7'b0, irq}, 8'h01);
    bus_rd(3'd2, v); check("R7 status bit7", v, 8'h80);
    bus_rd(3'd2, v); check("R7 read does not clear", v, 8'h80);
    nxt(); check("R7 irq held after reads", {7'b0, irq}, 8'h01);
    bus_wr(3'd3, 8'h00); nxt();
    check("R7 disable clears irq", {7'b0, irq}, 8'h00);
    bus_rd(3'd2, v); check("R7 status cleared", v, 8'h00);
  endtask

  task automatic t_uart();
    bus_wr(3'd1, 8'h00);
    uart_irq = 1'b1; nxt(); check("R11 passthrough unmasked", {7'b0, irq}, 8'h01);
    uart_irq = 1'b0; nxt(); check("R11 passthrough drop", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_edge();
    bus_wr(3'd0, 8'h00); bus_wr(3'd1, 8'h01);
    rx_half = 1'b1; nxt(); check("R10 pulse high", {7'b0, irq}, 8'h01);
    nxt(); check("R10 pulse one clock", {7'b0, irq}, 8'h00);
    uart_irq = 1'b1; nxt(); nxt();
    check("R10 no pulse while high", {7'b0, irq}, 8'h00);
    uart_irq = 1'b0; rx_half = 1'b0; nxt();
    rx_half = 1'b1; nxt(); check("R10 second pulse", {7'b0, irq}, 8'h01);
    nxt(); check("R10 second pulse ends", {7'b0, irq}, 8'h00);
    rx_half = 1'b0; nxt();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 0; rd = 0; rx_half = 0; rx_rd = 0;
    char_tmo = 0; tx_empty = 0; tx_wr = 0; tx_half = 0; tick = 0; uart_irq = 0;
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (3) nxt();
    t_reset();
    t_regs();
    t_rxhalf();
    t_cto();
    t_setwins();
    t_txe();
    t_txh();
    t_timer();
    t_uart();
    t_edge();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule